// File: doc/BRIEF.md
# I2C Target Register Control Port

This block lets an I2C controller reach a bank of byte-wide registers inside the chip. The block samples SCL and SDA with the system clock, recognises bus conditions, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero. Its 7-bit bus address is a fixed five-bit prefix (binary 10011) with two strap inputs appended as the low bits. The strap inputs are captured while reset is held.

A write transfer carries a pointer byte after the address. The top bit of the pointer byte asks for stepping, and the low seven bits name a register. Each data byte that follows is issued on a one-cycle write strobe. The pointer steps after each data byte only when stepping was requested. A read transfer returns the register the pointer names, and it returns that same register for every byte of the burst. To read a chosen register, the controller first sends a write that holds only the pointer byte and ends it with a Stop. The register bank sits outside the block: writes leave through the strobe outputs, and read data returns combinationally on the read-data input for the address the block presents.

Top module: `i2c_regport`

## Requirements
- R1: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. A Start restarts address reception from any state, including in the middle of a transfer (repeated Start). A Stop returns the block to idle with SDA released.
- R2: The first byte after a Start is the address in bits 7..1 and R/W in bit 0 (1 = read). The block acknowledges by pulling SDA low during the ninth clock only when the address equals binary 10011 followed by the two latched strap bits (strap bit 1 above strap bit 0).
- R3: The strap inputs are sampled only while rst is high. Changing them after reset does not change which address is answered.
- R4: On an address mismatch the block gives no acknowledge, keeps SDA released and issues no write for any later byte, until the next Start or Stop. After that Start it answers a matching address again.
- R5: In a write transfer the byte after the address is the pointer byte. Bit 7 is the stepping flag and bits 6..0 become the pointer. The block acknowledges it.
- R6: Each write data byte is acknowledged and produces exactly one single-cycle reg_wr_en pulse, with reg_wr_addr equal to the pointer and reg_wr_data equal to the byte. With the stepping flag set, the pointer advances by one after each data byte and wraps from 127 to 0. With the flag clear, the pointer stays put.
- R7: A Stop that follows the acknowledge of the pointer byte ends the transfer with no write, and the new pointer is kept for later reads.
- R8: A read transfer shifts out the register at the pointer, MSB first, for every byte of the burst. Reads never change the pointer, and reg_rd_addr always shows the pointer.
- R9: When the controller answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and keeps it released until the next Start or Stop.
- R10: While rst is high and right after it, SDA is released, reg_wr_en is low and the pointer is 0.
- R11: The SDA enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Low two bits of the bus address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 7 | Register index of the write |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_addr | output | 7 | Current pointer, used as the read index |
| reg_rd_data | input | 8 | Register contents at reg_rd_addr, combinational |

## Verification
The assertions assume a well-behaved controller. SCL stays at one level for several system clocks at a time. SDA moves only while SCL is low, except when it forms a Start or a Stop. The controller never issues a Start or Stop while the block is holding SDA low. Data bytes are also at least one full bus byte apart, so strobes cannot touch each other. The bench drives the bus by hand in quarter-bit steps of six system clocks. It changes SDA only in the quarter after SCL falls and holds the straps steady throughout every reset, so all stimulus stays inside these assumptions.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int IDX_W   = 7;
    localparam int STRAP_W = 2;
    localparam int DADDR_W = 7;
    localparam int PFX_W   = DADDR_W - STRAP_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MAP,
        ST_MAP_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [DADDR_W-1:0] a,
                                      input logic [PFX_W-1:0]   pfx,
                                      input logic [STRAP_W-1:0] strap);
        return a == {pfx, strap};
    endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= {W{RST_VAL}};
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= {W{RST_VAL}};
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rp_busmon.sv
module i2c_rp_busmon import i2c_rp_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [1:0] lines_s;
    logic       scl_p, sda_p;

    i2c_rp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (lines_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= lines_s[1];
            sda_p <= lines_s[0];
        end
    end

    always_comb begin
        ev.scl      = lines_s[1];
        ev.sda      = lines_s[0];
        ev.scl_rise = lines_s[1] & ~scl_p;
        ev.scl_fall = ~lines_s[1] & scl_p;
        ev.start    = lines_s[1] & scl_p & sda_p & ~lines_s[0];
        ev.stop     = lines_s[1] & scl_p & ~sda_p & lines_s[0];
    end
endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr import i2c_rp_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_val,
    input  logic             step_en,
    output logic [IDX_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)          ptr <= '0;
        else if (set_en)  ptr <= set_val;
        else if (step_en) ptr <= ptr + IDX_W'(1);
    end
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine import i2c_rp_pkg::*; #(
    parameter logic [PFX_W-1:0] DEV_PREFIX = 5'b10011
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic [IDX_W-1:0]   ptr,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output wr_req_t            wr,
    output logic               ptr_set,
    output logic [IDX_W-1:0]   ptr_val,
    output logic               ptr_step,
    output logic               in_read,
    output logic               ignoring
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    state_t            st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] byte_in;
    logic              ack_ph, rw_q, incr_q, oe_q;
    logic              last_bit;
    wr_req_t           wr_q;

    assign byte_in  = {sh[BYTE_W-2:0], ev.sda};
    assign last_bit = ev.scl_rise && (cnt == LAST) && !ev.start && !ev.stop;

    assign ptr_set  = (st == ST_MAP) && last_bit;
    assign ptr_val  = byte_in[IDX_W-1:0];
    assign ptr_step = wr_q.en & incr_q;
    assign sda_oe   = oe_q;
    assign wr       = wr_q;
    assign in_read  = (st == ST_RDATA) || (st == ST_RACK);
    assign ignoring = (st == ST_IGNORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            ack_ph <= 1'b0;
            rw_q   <= 1'b0;
            incr_q <= 1'b0;
            oe_q   <= 1'b0;
            wr_q   <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                oe_q   <= 1'b0;
                ack_ph <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                oe_q   <= 1'b0;
                ack_ph <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_MAP, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            sh  <= byte_in;
                            cnt <= cnt + CNT_W'(1);
                            if (cnt == LAST) begin
                                if (st == ST_ADDR) begin
                                    if (addr_hit(byte_in[BYTE_W-1:1], DEV_PREFIX, strap)) begin
                                        rw_q <= byte_in[0];
                                        st   <= ST_ADDR_ACK;
                                    end else begin
                                        st   <= ST_IGNORE;
                                    end
                                end else if (st == ST_MAP) begin
                                    incr_q <= byte_in[BYTE_W-1];
                                    st     <= ST_MAP_ACK;
                                end else begin
                                    wr_q.en   <= 1'b1;
                                    wr_q.idx  <= ptr;
                                    wr_q.data <= byte_in;
                                    st        <= ST_WDATA_ACK;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_MAP_ACK, ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            if (!ack_ph) begin
                                ack_ph <= 1'b1;
                                oe_q   <= 1'b1;
                            end else begin
                                ack_ph <= 1'b0;
                                oe_q   <= 1'b0;
                                cnt    <= '0;
                                if (st == ST_ADDR_ACK && rw_q) begin
                                    st   <= ST_RDATA;
                                    sh   <= rd_data;
                                    oe_q <= ~rd_data[BYTE_W-1];
                                end else if (st == ST_ADDR_ACK) begin
                                    st <= ST_MAP;
                                end else begin
                                    st <= ST_WDATA;
                                end
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            cnt <= cnt + CNT_W'(1);
                            if (cnt == LAST) begin
                                oe_q <= 1'b0;
                                st   <= ST_RACK;
                            end else begin
                                sh   <= {sh[BYTE_W-2:0], 1'b0};
                                oe_q <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            if (ev.sda) st <= ST_IGNORE;
                            else        ack_ph <= 1'b1;
                        end else if (ev.scl_fall && ack_ph) begin
                            ack_ph <= 1'b0;
                            cnt    <= '0;
                            sh     <= rd_data;
                            oe_q   <= ~rd_data[BYTE_W-1];
                            st     <= ST_RDATA;
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport import i2c_rp_pkg::*; #(
    parameter int               SYNC_STAGES = 2,
    parameter logic [PFX_W-1:0] DEV_PREFIX  = 5'b10011
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               reg_wr_en,
    output logic [IDX_W-1:0]   reg_wr_addr,
    output logic [BYTE_W-1:0]  reg_wr_data,
    output logic [IDX_W-1:0]   reg_rd_addr,
    input  logic [BYTE_W-1:0]  reg_rd_data
);
    bus_ev_t            ev;
    wr_req_t            wr;
    logic [STRAP_W-1:0] strap_q;
    logic [IDX_W-1:0]   ptr, ptr_val;
    logic               ptr_set, ptr_step;
    logic               in_read, ignoring;
    logic               scl_sync;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_i;
    end

    i2c_rp_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rp_engine #(.DEV_PREFIX(DEV_PREFIX)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .strap    (strap_q),
        .ptr      (ptr),
        .rd_data  (reg_rd_data),
        .sda_oe   (sda_oe),
        .wr       (wr),
        .ptr_set  (ptr_set),
        .ptr_val  (ptr_val),
        .ptr_step (ptr_step),
        .in_read  (in_read),
        .ignoring (ignoring)
    );

    i2c_rp_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .set_en  (ptr_set),
        .set_val (ptr_val),
        .step_en (ptr_step),
        .ptr     (ptr)
    );

    assign scl_sync    = ev.scl;
    assign reg_wr_en   = wr.en;
    assign reg_wr_addr = wr.idx;
    assign reg_wr_data = wr.data;
    assign reg_rd_addr = ptr;
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk import i2c_rp_pkg::*; (
    input logic               clk,
    input logic               rst,
    input logic               scl_sync,
    input logic               sda_oe,
    input logic               reg_wr_en,
    input logic [IDX_W-1:0]   reg_rd_addr,
    input logic               in_read,
    input logic               ignoring,
    input logic [STRAP_W-1:0] strap_q
);
    // R10: first cycle out of reset is quiet
    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_oe && !reg_wr_en && reg_rd_addr == '0));

    // R11: drive changes only while SCL is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_sync);

    // R6: strobe lasts one cycle
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R8: pointer frozen throughout a read
    assert_read_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (in_read && $past(in_read)) |-> $stable(reg_rd_addr));

    // R4: ignored transfer drives nothing
    assert_ignore_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ignoring |-> (!sda_oe && !reg_wr_en));

    // R3: straps frozen once out of reset
    assert_strap_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_q));
endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_sync    (scl_sync),
    .sda_oe      (sda_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_addr (reg_rd_addr),
    .in_read     (in_read),
    .ignoring    (ignoring),
    .strap_q     (strap_q)
);

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
    import i2c_rp_pkg::*;

    localparam int Q = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst   = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_oe, reg_wr_en;
    logic [6:0] reg_wr_addr, reg_rd_addr;
    logic [7:0] reg_wr_data, reg_rd_data;
    logic       sda_line;

    logic [7:0] mem    [128];
    logic [7:0] shadow [128];

    typedef struct { logic [6:0] a; logic [7:0] d; } exp_t;
    exp_t exp_q [$];
    exp_t mon_e;

    int  checks = 0, fails = 0, oe_viol = 0;
    bit  done = 0;
    logic oe_prev = 1'b0;

    assign sda_line    = m_sda & ~sda_oe;
    assign reg_rd_data = mem[reg_rd_addr];

    i2c_regport dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .strap_i     (strap),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // scoreboard monitor (R6)
    always @(negedge clk) begin
        if (!rst && reg_wr_en) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R6 unexpected write actual=%0h expected=none",
                         {reg_wr_addr, reg_wr_data});
            end else begin
                mon_e = exp_q.pop_front();
                chk(reg_wr_addr == mon_e.a && reg_wr_data == mon_e.d, "R6 write",
                    {reg_wr_addr, reg_wr_data}, {mon_e.a, mon_e.d});
            end
            mem[reg_wr_addr] = reg_wr_data;
        end
    end

    // R11 watcher
    always @(negedge clk) begin
        if (!rst && sda_oe != oe_prev && m_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; quarter();
        m_scl = 1'b1; quarter();
        m_sda = 1'b0; quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; quarter();
        m_scl = 1'b1; quarter();
        m_sda = 1'b1; quarter();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; quarter();
            m_scl = 1'b1; quarter(); quarter();
            m_scl = 1'b0;
        end
        m_sda = 1'b1; quarter();
        m_scl = 1'b1; quarter();
        ack = !sda_line;
        quarter();
        m_scl = 1'b0; quarter();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit nack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            quarter();
            m_scl = 1'b1; quarter();
            b[i] = sda_line;
            quarter();
            m_scl = 1'b0;
        end
        m_sda = nack; quarter();
        m_scl = 1'b1; quarter(); quarter();
        m_scl = 1'b0; quarter();
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic [1:0] s, input bit rd);
        return {5'b10011, s, rd};
    endfunction

    task automatic wr_xfer(input logic [1:0] s, input logic [7:0] mapb, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [6:0] idx;
        logic [7:0] dv [3];
        bit ack;
        exp_t e;
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        idx = mapb[6:0];
        for (int k = 0; k < n; k++) begin
            e.a = idx; e.d = dv[k];
            exp_q.push_back(e);
            shadow[idx] = dv[k];
            if (mapb[7]) idx = idx + 7'd1;
        end
        bus_start();
        send_byte(dev(s, 1'b0), ack);
        chk(ack, "R2 address ack", ack, 1);
        send_byte(mapb, ack);
        chk(ack, "R5 pointer ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(dv[k], ack);
            chk(ack, "R6 data ack", ack, 1);
        end
        bus_stop();
        quarter();
        chk(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
    endtask

    task automatic rd_xfer(input logic [1:0] s, input int n, input logic [6:0] p);
        logic [7:0] b;
        bit ack;
        bus_start();
        send_byte(dev(s, 1'b1), ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k == n - 1);
            chk(b == shadow[p], "R8 read data", b, shadow[p]);
        end
        chk(reg_rd_addr == p, "R8 pointer unchanged by read", reg_rd_addr, p);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]    = 8'((i * 37 + 5) & 8'hFF);
            shadow[i] = 8'((i * 37 + 5) & 8'hFF);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        bit ack;
        int seen;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sda_oe, "R10 sda released", sda_oe, 0);
        chk(!reg_wr_en, "R10 no strobe", reg_wr_en, 0);
        chk(reg_rd_addr == 0, "R10 pointer zero", reg_rd_addr, 0);
        quarter();

        // R6 fixed pointer: both bytes to reg 5
        wr_xfer(2'b01, 8'h05, 2, 8'h11, 8'h22, 8'h00);
        chk(reg_rd_addr == 7'h05, "R6 pointer held without flag", reg_rd_addr, 5);

        // R6 stepping
        wr_xfer(2'b01, 8'h90, 3, 8'hA1, 8'hA2, 8'hA3);
        chk(reg_rd_addr == 7'h13, "R6 pointer stepped", reg_rd_addr, 7'h13);

        // R6 wrap
        wr_xfer(2'b01, 8'hFF, 2, 8'h55, 8'h66, 8'h00);
        chk(reg_rd_addr == 7'h01, "R6 pointer wraps", reg_rd_addr, 1);

        // R7 pointer-only preamble then R8 burst read
        wr_xfer(2'b01, 8'h20, 0, 8'h00, 8'h00, 8'h00);
        chk(reg_rd_addr == 7'h20, "R7 pointer kept after stop", reg_rd_addr, 7'h20);
        rd_xfer(2'b01, 3, 7'h20);
        // R9: after NACK the bus stays released
        recv_byte(b, 1'b1);
        chk(b == 8'hFF, "R9 released after NACK", b, 8'hFF);
        bus_stop();
        quarter();

        // R1 repeated start: pointer then read of written reg 0x10
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack);
        chk(ack, "R1 address ack", ack, 1);
        send_byte(8'h10, ack);
        chk(ack, "R5 pointer ack", ack, 1);
        rd_xfer(2'b01, 1, 7'h10);
        bus_stop();
        quarter();

        // R4 mismatch: strap bits wrong
        seen = checks;
        bus_start();
        send_byte(dev(2'b00, 1'b0), ack);
        chk(!ack, "R4 no ack on mismatch", ack, 0);
        send_byte(8'h81, ack);
        chk(!ack, "R4 pointer byte ignored", ack, 0);
        send_byte(8'h77, ack);
        chk(!ack, "R4 data byte ignored", ack, 0);
        bus_stop();
        quarter();
        chk(reg_rd_addr == 7'h10, "R4 pointer untouched", reg_rd_addr, 7'h10);
        chk(mem[1] == shadow[1], "R4 no register change", mem[1], shadow[1]);

        // R2 mismatch in prefix bits
        bus_start();
        send_byte(8'h1A, ack);
        chk(!ack, "R2 prefix mismatch no ack", ack, 0);
        // R1/R4: new start answered again
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack);
        chk(ack, "R1 start after ignore acks", ack, 1);
        bus_stop();
        quarter();

        // R3: straps changed after reset have no effect
        strap = 2'b10;
        quarter();
        bus_start();
        send_byte(dev(2'b10, 1'b0), ack);
        chk(!ack, "R3 new strap not answered", ack, 0);
        bus_stop();
        quarter();
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack);
        chk(ack, "R3 latched strap answered", ack, 1);
        bus_stop();
        quarter();

        // R3 / R10: second reset picks up new straps
        @(negedge clk);
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(reg_rd_addr == 0, "R10 pointer zero after reset", reg_rd_addr, 0);
        chk(!sda_oe, "R10 released after reset", sda_oe, 0);
        quarter();
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack);
        chk(!ack, "R3 old strap dropped", ack, 0);
        bus_stop();
        quarter();
        rd_xfer(2'b10, 2, 7'h00);
        bus_stop();
        quarter();

        chk(oe_viol == 0, "R11 drive changes with SCL low", oe_viol, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule